// File: doc/BRIEF.md
# Multicycle Accumulator Processor with Index Registers

This block is a small processor built around one accumulator. Each instruction is an 18-bit word holding an operation, an addressing mode and a 13-bit address field. A control state machine walks every instruction through a fixed cycle: fetch, decode, address evaluation, operand fetch, execute and, for stores, a write-back. Program and data share one memory, which lies outside the block and is reached through a single request port.

The request port follows a valid/ready rule. The block raises `mem_valid` with address, write flag and write data. It holds all of them unchanged until `mem_ready` is seen high at a clock edge. Reads are answered by the memory with `mem_rvalid` and `mem_rdata` one or more cycles later. Only one read is ever outstanding, and the block waits for the answer before it issues anything else. The accumulator, the carry flag and a halt flag are brought out as plain status pins.

Top module: `acc_cpu`

## Requirements
- R1: After reset the accumulator, carry, program counter and both index registers are zero, `halted` is low, and the first request is a read of address 0.
- R2: Word bits 17:15 hold the operation: 000 load, 001 store, 010 add, 011 subtract, 100 and, 101 or/not, 110 jump, 111 conditional jump. An operand for load, add, subtract, and, and or is read from the effective address unless the mode is immediate.
- R3: Word bits 14:13 hold the mode: 00 uses the field as the address. 01 reads a pointer at the field and uses its low 13 bits. 10 adds the field bits 11:0 to an index register, chosen by field bit 12 (0 first, 1 second), modulo 2^13. 11 uses the field, zero-extended, as the operand or target.
- R4: Add and subtract are two's-complement on 18 bits. Add sets carry to the carry out. Subtract sets carry when no borrow occurs.
- R5: Field bit 0 of operation 101 picks OR (0) with the operand or NOT (1) of the accumulator. AND, OR, NOT and load leave carry unchanged.
- R6: A store with a non-immediate mode writes the accumulator to the effective address. A store in immediate mode writes no memory. It copies accumulator bits 12:0 into the first index register when field bit 0 is 0, and into the second when it is 1.
- R7: The program counter steps by one after each fetch. A jump loads it with the effective address. Operation 111 does so only when the accumulator is zero (field bit 0 = 0) or when carry is set (field bit 0 = 1).
- R8: A fetched word of all ones stops the processor. `halted` rises and stays high, and no further request is made.
- R9: While `mem_valid` is high and `mem_ready` low, address, write flag and write data stay unchanged.
- R10: Each instruction issues its requests in this order: fetch, pointer read (indirect only), operand read, write.
- R11: The accumulator changes only in the execute step. Carry changes only on add or subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_valid | output | 1 | Memory request offered |
| mem_ready | input | 1 | Memory accepts the request at this edge |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 13 | Request address |
| mem_wdata | output | 18 | Write data (accumulator) |
| mem_rvalid | input | 1 | Read answer present |
| mem_rdata | input | 18 | Read answer data |
| acc_o | output | 18 | Accumulator |
| carry_o | output | 1 | Carry flag |
| halted | output | 1 | Processor stopped on the halt word |

## Verification
A request is due in the cycle the machine enters its fetch, pointer, operand or write step. The bench compares it against the reference instruction model in the very cycle it is accepted, and checks in each stalled cycle that the held request has not moved. Read answers come one cycle after acceptance. The halt flag is due two edges after the halt word's answer, since one edge loads the instruction and the next leaves decode. Accumulator, carry and memory contents are compared only once `halted` is high, when no later edge can alter them.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_AND   = 3'd4,
    OP_ORNOT = 3'd5,
    OP_JMP   = 3'd6,
    OP_JCOND = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    MD_DIR = 2'd0,
    MD_IND = 2'd1,
    MD_IDX = 2'd2,
    MD_IMM = 2'd3
  } mode_e;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_FWAIT,
    ST_DECODE,
    ST_EVAL,
    ST_IWAIT,
    ST_OPER,
    ST_OWAIT,
    ST_EXEC,
    ST_STORE,
    ST_HALT
  } state_e;

  typedef enum logic [1:0] {
    AS_PC,
    AS_FIELD,
    AS_EA
  } asel_e;

endpackage

// File: rtl/acc_cpu_agen.sv
module acc_cpu_agen
  import acc_cpu_pkg::*;
#(
  parameter int AW = 13
) (
  input  mode_e         mode,
  input  logic [AW-1:0] field,
  input  logic [AW-1:0] ix_a,
  input  logic [AW-1:0] ix_b,
  output logic [AW-1:0] ea
);

  logic [AW-1:0] ix_sel;
  logic [AW-1:0] offset;

  // top field bit picks the index register, the rest is the offset
  assign ix_sel = field[AW-1] ? ix_b : ix_a;
  assign offset = {1'b0, field[AW-2:0]};

  always_comb begin
    unique case (mode)
      MD_IDX:  ea = offset + ix_sel;
      default: ea = field;
    endcase
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 18
) (
  input  op_e           op,
  input  logic          sel,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] md,
  output logic [DW-1:0] acc_n,
  output logic          cf_n,
  output logic          acc_we,
  output logic          cf_we
);

  logic [DW:0] sum_add;
  logic [DW:0] sum_sub;

  assign sum_add = {1'b0, acc} + {1'b0, md};
  assign sum_sub = {1'b0, acc} + {1'b0, ~md} + (DW+1)'(1);

  always_comb begin
    acc_n  = acc;
    cf_n   = 1'b0;
    acc_we = 1'b0;
    cf_we  = 1'b0;
    unique case (op)
      OP_LOAD: begin
        acc_n  = md;
        acc_we = 1'b1;
      end
      OP_ADD: begin
        acc_n  = sum_add[DW-1:0];
        cf_n   = sum_add[DW];
        acc_we = 1'b1;
        cf_we  = 1'b1;
      end
      OP_SUB: begin
        acc_n  = sum_sub[DW-1:0];
        cf_n   = sum_sub[DW];
        acc_we = 1'b1;
        cf_we  = 1'b1;
      end
      OP_AND: begin
        acc_n  = acc & md;
        acc_we = 1'b1;
      end
      OP_ORNOT: begin
        acc_n  = sel ? ~acc : (acc | md);
        acc_we = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  op_e    op,
  input  mode_e  mode,
  input  logic   sel,
  input  logic   halt_word,
  input  logic   mem_ready,
  input  logic   mem_rvalid,
  output state_e state,
  output logic   need_rd,
  output logic   req_valid,
  output logic   req_we,
  output asel_e  addr_sel
);

  state_e nxt;

  always_comb begin
    need_rd = 1'b0;
    if (mode != MD_IMM) begin
      unique case (op)
        OP_LOAD, OP_ADD, OP_SUB, OP_AND: need_rd = 1'b1;
        OP_ORNOT:                        need_rd = !sel;
        default:                         need_rd = 1'b0;
      endcase
    end
  end

  always_comb begin
    nxt       = state;
    req_valid = 1'b0;
    req_we    = 1'b0;
    addr_sel  = AS_PC;
    unique case (state)
      ST_FETCH: begin
        req_valid = 1'b1;
        if (mem_ready) nxt = ST_FWAIT;
      end
      ST_FWAIT:  if (mem_rvalid) nxt = ST_DECODE;
      ST_DECODE: nxt = halt_word ? ST_HALT : ST_EVAL;
      ST_EVAL: begin
        if (mode == MD_IND) begin
          req_valid = 1'b1;
          addr_sel  = AS_FIELD;
          if (mem_ready) nxt = ST_IWAIT;
        end else begin
          nxt = ST_OPER;
        end
      end
      ST_IWAIT: if (mem_rvalid) nxt = ST_OPER;
      ST_OPER: begin
        if (need_rd) begin
          req_valid = 1'b1;
          addr_sel  = AS_EA;
          if (mem_ready) nxt = ST_OWAIT;
        end else begin
          nxt = ST_EXEC;
        end
      end
      ST_OWAIT: if (mem_rvalid) nxt = ST_EXEC;
      ST_EXEC:  nxt = (op == OP_STORE && mode != MD_IMM) ? ST_STORE : ST_FETCH;
      ST_STORE: begin
        req_valid = 1'b1;
        req_we    = 1'b1;
        addr_sel  = AS_EA;
        if (mem_ready) nxt = ST_FETCH;
      end
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mem_ready) |=> (req_valid && $stable(req_we))); // R9

  AST_ANSWER_AWAITED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (state == ST_FWAIT || state == ST_IWAIT || state == ST_OWAIT)); // R10

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> (state == ST_HALT)); // R8

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> !req_valid); // R8

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [AW+4:0]       mem_wdata,
  input  logic                mem_rvalid,
  input  logic [AW+4:0]       mem_rdata,
  output logic [AW+4:0]       acc_o,
  output logic                carry_o,
  output logic                halted
);

  localparam int DW = AW + 5;

  logic [AW-1:0] pc_q, ea_q, ia_q, ib_q;
  logic [DW-1:0] ir_q, acc_q, md_q;
  logic          cf_q;

  op_e           op;
  mode_e         mode;
  logic [AW-1:0] field;
  logic          sel;
  logic          halt_word;

  assign op        = op_e'(ir_q[DW-1 -: 3]);
  assign mode      = mode_e'(ir_q[AW+1:AW]);
  assign field     = ir_q[AW-1:0];
  assign sel       = field[0];
  assign halt_word = &ir_q;

  state_e        state;
  logic          need_rd;
  logic          req_valid, req_we;
  asel_e         addr_sel;

  acc_cpu_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .mode       (mode),
    .sel        (sel),
    .halt_word  (halt_word),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .state      (state),
    .need_rd    (need_rd),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .addr_sel   (addr_sel)
  );

  logic [AW-1:0] ea_comb;

  acc_cpu_agen #(.AW(AW)) u_agen (
    .mode  (mode),
    .field (field),
    .ix_a  (ia_q),
    .ix_b  (ib_q),
    .ea    (ea_comb)
  );

  logic [DW-1:0] acc_n;
  logic          cf_n, acc_we, cf_we;

  acc_cpu_alu #(.DW(DW)) u_alu (
    .op     (op),
    .sel    (sel),
    .acc    (acc_q),
    .md     (md_q),
    .acc_n  (acc_n),
    .cf_n   (cf_n),
    .acc_we (acc_we),
    .cf_we  (cf_we)
  );

  logic jump_take;

  always_comb begin
    unique case (op)
      OP_JMP:   jump_take = 1'b1;
      OP_JCOND: jump_take = sel ? cf_q : (acc_q == '0);
      default:  jump_take = 1'b0;
    endcase
  end

  always_comb begin
    unique case (addr_sel)
      AS_FIELD: mem_addr = field;
      AS_EA:    mem_addr = ea_q;
      default:  mem_addr = pc_q;
    endcase
  end

  assign mem_valid = req_valid;
  assign mem_we    = req_we;
  assign mem_wdata = acc_q;
  assign acc_o     = acc_q;
  assign carry_o   = cf_q;
  assign halted    = (state == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ea_q  <= '0;
      ia_q  <= '0;
      ib_q  <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      md_q  <= '0;
      cf_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_FWAIT: if (mem_rvalid) begin
          ir_q <= mem_rdata;
          pc_q <= pc_q + AW'(1);
        end
        ST_EVAL:  if (mode != MD_IND) ea_q <= ea_comb;
        ST_IWAIT: if (mem_rvalid) ea_q <= mem_rdata[AW-1:0];
        ST_OPER:  if (!need_rd) md_q <= {{(DW-AW){1'b0}}, field};
        ST_OWAIT: if (mem_rvalid) md_q <= mem_rdata;
        ST_EXEC: begin
          if (acc_we) acc_q <= acc_n;
          if (cf_we)  cf_q  <= cf_n;
          if (jump_take) pc_q <= ea_q;
          if (op == OP_STORE && mode == MD_IMM) begin
            if (sel) ib_q <= acc_q[AW-1:0];
            else     ia_q <= acc_q[AW-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  AST_REQ_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata))); // R9

  AST_ACC_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_EXEC) |=> $stable(acc_q)); // R11

  AST_CARRY_ARITH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cf_q) |-> ($past(state) == ST_EXEC &&
                        ($past(op) == OP_ADD || $past(op) == OP_SUB))); // R11

  AST_PC_STEP_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE) |-> (pc_q == $past(pc_q) + AW'(1))); // R7

endmodule

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;

  typedef struct packed {
    logic        we;
    logic [12:0] addr;
    logic [17:0] data;
    logic [1:0]  kind;
  } xact_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_valid, mem_we, mem_rvalid, carry_o, halted;
  logic        ready_r = 1'b0;
  logic [12:0] mem_addr;
  logic [17:0] mem_wdata, mem_rdata, acc_o;
  logic [17:0] dmem [0:255];
  logic [17:0] rm   [0:255];
  logic [17:0] prog [0:255];
  logic [15:0] lfsr = 16'hACE1;
  xact_t       exp_q [$];
  logic [17:0] exp_acc;
  logic        exp_cf;
  int          n_chk = 0;
  int          n_err = 0;

  always #2.5 clk = ~clk;

  acc_cpu i_acc_cpu (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_valid  (mem_valid),
    .mem_ready  (ready_r),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .acc_o      (acc_o),
    .carry_o    (carry_o),
    .halted     (halted)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_valid && ready_r) begin
        if (mem_we) dmem[mem_addr[7:0]] <= mem_wdata;
        else begin
          mem_rdata  <= dmem[mem_addr[7:0]];
          mem_rvalid <= 1'b1;
        end
      end
    end
  end

  function automatic logic [17:0] enc(input logic [2:0] op, input logic [1:0] md,
                                      input logic [12:0] f);
    return {op, md, f};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [12:0] a, input logic [17:0] d,
                      input logic [1:0] k);
    xact_t x;
    x.we = we; x.addr = a; x.data = d; x.kind = k;
    exp_q.push_back(x);
  endtask

  // instruction-level reference: kinds 0 fetch, 1 pointer, 2 operand, 3 write
  task automatic ref_run();
    logic [12:0] pc = '0, ia = '0, ib = '0, ea, f;
    logic [17:0] ac = '0, ir, opv;
    logic [18:0] s;
    logic [2:0]  op;
    logic [1:0]  md;
    logic        cf = 1'b0, rd;
    for (int step = 0; step < 1000; step++) begin
      push(1'b0, pc, '0, 2'd0);
      ir = rm[pc[7:0]];
      pc = pc + 13'd1;
      if (ir == 18'h3FFFF) break;
      op = ir[17:15]; md = ir[14:13]; f = ir[12:0];
      if (md == 2'd0) ea = f;
      else if (md == 2'd1) begin
        push(1'b0, f, '0, 2'd1);
        ea = rm[f[7:0]][12:0];
      end else if (md == 2'd2) ea = {1'b0, f[11:0]} + (f[12] ? ib : ia);
      else ea = f;
      rd = (md != 2'd3) && (op == 3'd0 || op == 3'd2 || op == 3'd3 || op == 3'd4 ||
                            (op == 3'd5 && !f[0]));
      if (rd) begin
        push(1'b0, ea, '0, 2'd2);
        opv = rm[ea[7:0]];
      end else opv = {5'd0, f};
      case (op)
        3'd0: ac = opv;
        3'd1: begin
          if (md == 2'd3) begin
            if (f[0]) ib = ac[12:0]; else ia = ac[12:0];
          end else begin
            push(1'b1, ea, ac, 2'd3);
            rm[ea[7:0]] = ac;
          end
        end
        3'd2: begin s = ac + opv; ac = s[17:0]; cf = s[18]; end
        3'd3: begin s = {1'b0, ac} + {1'b0, ~opv} + 19'd1; ac = s[17:0]; cf = s[18]; end
        3'd4: ac = ac & opv;
        3'd5: ac = f[0] ? ~ac : (ac | opv);
        3'd6: pc = ea;
        default: if (f[0] ? cf : (ac == 18'd0)) pc = ea;
      endcase
    end
    exp_acc = ac;
    exp_cf  = cf;
  endtask

  task automatic run_prog(input bit stall, input string acc_tag, input string cf_tag);
    xact_t       e;
    logic        pend = 1'b0, p_we = 1'b0, ok, quiet;
    logic [12:0] p_addr = '0;
    logic [17:0] p_wd = '0;
    int          cyc = 0, bad = 0;
    string       tag;
    rst_n   = 1'b0;
    ready_r = 1'b0;
    for (int i = 0; i < 256; i++) begin dmem[i] = prog[i]; rm[i] = prog[i]; end
    exp_q.delete();
    ref_run();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values and first request at address 0
    chk(mem_valid && mem_addr == 13'd0 && !mem_we && !halted && acc_o == 18'd0 && !carry_o,
        "R1", {mem_valid, mem_addr}, 32'h2000);
    while (!halted && cyc < 5000) begin
      ready_r = stall ? (lfsr[1:0] != 2'b00) : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (pend)
        chk(mem_valid && mem_addr == p_addr && mem_we == p_we && (!p_we || mem_wdata == p_wd),
            "R9", {mem_valid, mem_addr}, {1'b1, p_addr});
      if (mem_valid && ready_r) begin
        if (exp_q.size() == 0) chk(1'b0, "R10", {mem_we, mem_addr}, 32'h0);
        else begin
          e  = exp_q.pop_front();
          ok = (e.we == mem_we) && (e.addr == mem_addr) && (!e.we || e.data == mem_wdata);
          case (e.kind)
            2'd0:    tag = "R10";
            2'd1:    tag = "R3";
            2'd2:    tag = "R2";
            default: tag = "R6";
          endcase
          chk(ok, tag, {mem_we, mem_addr, mem_wdata}, {e.we, e.addr, e.data});
        end
      end
      pend   = mem_valid && !ready_r;
      p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
      @(negedge clk);
      cyc++;
    end
    if (!halted) chk(1'b0, "R8 watchdog", cyc, 5000);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    chk(acc_o == exp_acc, acc_tag, acc_o, exp_acc);
    chk(carry_o == exp_cf, cf_tag, carry_o, exp_cf);
    for (int i = 0; i < 256; i++) if (dmem[i] !== rm[i]) bad++;
    chk(bad == 0, "R6", bad, 0);
    ready_r = 1'b1;
    quiet = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (mem_valid || !halted) quiet = 1'b0;
    end
    chk(quiet, "R8", {mem_valid, halted}, 32'h1);
  endtask

  task automatic load_prog1();
    for (int i = 0; i < 256; i++) prog[i] = '0;
    prog[0]  = enc(3'd0, 2'd3, 13'd5);
    prog[1]  = enc(3'd2, 2'd0, 13'd200);
    prog[2]  = enc(3'd7, 2'd3, 13'd7);
    for (int i = 3; i < 7; i++) prog[i] = enc(3'd0, 2'd3, 13'd1);
    prog[7]  = enc(3'd1, 2'd0, 13'd201);
    prog[8]  = enc(3'd3, 2'd3, 13'd4);
    prog[9]  = enc(3'd7, 2'd3, 13'd12);
    prog[10] = enc(3'd0, 2'd3, 13'd9);
    prog[11] = enc(3'd0, 2'd3, 13'd9);
    prog[12] = enc(3'd3, 2'd3, 13'd1);
    prog[13] = enc(3'd7, 2'd3, 13'd17);
    prog[14] = enc(3'd4, 2'd0, 13'd203);
    prog[15] = enc(3'd5, 2'd3, 13'h100);
    prog[16] = enc(3'd5, 2'd3, 13'd1);
    prog[17] = enc(3'd1, 2'd0, 13'd204);
    prog[18] = 18'h3FFFF;
    prog[200] = 18'h3FFFF;
    prog[203] = 18'h0F0F0;
  endtask

  task automatic load_prog2();
    for (int i = 0; i < 256; i++) prog[i] = '0;
    prog[0]  = enc(3'd0, 2'd3, 13'd3);
    prog[1]  = enc(3'd1, 2'd3, 13'd0);
    prog[2]  = enc(3'd0, 2'd3, 13'd100);
    prog[3]  = enc(3'd1, 2'd3, 13'd1);
    prog[4]  = enc(3'd0, 2'd2, 13'd200);
    prog[5]  = enc(3'd2, 2'd2, 13'h1000 | 13'd10);
    prog[6]  = enc(3'd1, 2'd1, 13'd210);
    prog[7]  = enc(3'd0, 2'd1, 13'd211);
    prog[8]  = enc(3'd1, 2'd2, 13'h1000 | 13'd20);
    prog[9]  = enc(3'd6, 2'd1, 13'd212);
    for (int i = 10; i < 14; i++) prog[i] = enc(3'd0, 2'd3, 13'd7);
    prog[14] = enc(3'd6, 2'd2, 13'd13);
    prog[15] = enc(3'd0, 2'd3, 13'd1);
    prog[16] = enc(3'd3, 2'd0, 13'd205);
    prog[17] = enc(3'd7, 2'd1, 13'd214);
    prog[18] = enc(3'd0, 2'd3, 13'd1);
    prog[19] = enc(3'd0, 2'd3, 13'd1);
    prog[20] = enc(3'd1, 2'd0, 13'd221);
    prog[21] = 18'h3FFFF;
    prog[203] = 18'h00010;
    prog[110] = 18'h3FFF8;
    prog[205] = 18'h12345;
    prog[210] = 18'd220;
    prog[211] = 18'd205;
    prog[212] = 18'd14;
    prog[214] = 18'd20;
  endtask

  initial begin
    load_prog1();
    run_prog(1'b0, "R5", "R11");
    load_prog2();
    run_prog(1'b1, "R4", "R4");
    load_prog1();
    run_prog(1'b1, "R5", "R11");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #750000;
    n_chk++;
    n_err++;
    $display("FAIL R8 watchdog expired actual=running expected=halted");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule